// File: doc/BRIEF.md
# Framed Serial Transmitter with Clock Preamble

This block sends one frame at a time on a single serial data line, together with a forwarded clock. Everything runs from one core clock. The forwarded clock runs at half the core rate. Every bit therefore lasts two core cycles: a high half, when the data line changes, and a low half, when a receiver samples it.

A producer presents a frame (type nibble, user byte, tag byte, word count and a packed payload) and holds a start request. When the transmitter is idle it takes a copy of the frame and pulses `accept`, so the producer can drop the request. It then drives the line in this order:
- a run of clock-only preamble periods;
- a fixed start-of-frame marker;
- the type, the user byte and the payload words;
- an 8-bit CRC, then the tag;
- a fixed end-of-frame marker;
- a run of clock-only postamble periods.

Last comes a one-cycle `done` pulse. A request that is still held while a frame is in flight waits for that frame to finish.

Top module: `fsx_frame_tx`

## Requirements
- R1: A synchronous active-low reset, applied at any time, returns the block to idle with `ser_clk`, `ser_dat`, `busy`, `accept` and `done` all low. After release no `done` pulse appears.
- R2: While `busy` is high, `ser_clk` toggles on every core cycle and starts high in the first busy cycle, so one serial period is two core cycles. While idle, `ser_clk` and `ser_dat` are both low.
- R3: `ser_dat` changes only in a cycle where `ser_clk` goes high. It holds its value through the following low half.
- R4: When `req` is sampled high on a core edge while idle, `busy` rises in the next cycle, and `accept` is high for exactly that one cycle, which is the first preamble cycle.
- R5: The first 4 serial periods of a frame carry data 0 (preamble).
- R6: After the preamble the line carries these fields, each sent MSB first:
  - start-of-frame bits 1, 0, 0, 1;
  - the 4-bit type;
  - the 8-bit user byte;
  - the payload words, word 0 first, where word i is `payload[16*i+15 : 16*i]`.
- R7: `n_words_m1` selects the word count as its value plus one, from 1 word (0) to 16 words (15).
- R8: After the last word the line carries:
  - an 8-bit CRC, MSB first: polynomial x^8+x^2+x+1 (0x07), initial value 0, no reflection, no final XOR, computed over the type, user and word bits in the order they are sent;
  - the 8-bit tag, MSB first;
  - end-of-frame bits 0, 1, 1, 0.
- R9: The last 4 serial periods carry data 0 (postamble). `busy` then lasts exactly 2*(44+16*N) core cycles for N words. `done` is high for one cycle, the first cycle with `busy` low.
- R10: The frame inputs are captured at acceptance, so changing them while `busy` is high does not alter the frame in flight. A `req` held high through a frame is not acted on until that frame ends, and is accepted in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start request, held until `accept` |
| frm_type | input | 4 | Frame type nibble |
| user_data | input | 8 | User byte |
| tag | input | 8 | Tag byte sent after the CRC |
| n_words_m1 | input | 4 | Number of payload words minus one |
| payload | input | 256 | Payload words, word i at bits 16*i+15 down to 16*i |
| ser_clk | output | 1 | Forwarded serial clock, half the core rate |
| ser_dat | output | 1 | Serial data, changes on the rising `ser_clk` |
| busy | output | 1 | High from the first preamble cycle to the last postamble cycle |
| accept | output | 1 | One-cycle pulse when a request is taken |
| done | output | 1 | One-cycle pulse after the postamble |

## Verification
Each wrong internal state shows at the ports, and within a known time:
- A phase register out of step shows on `ser_clk` in the very next core cycle, since the clock must alternate from a high first half.
- A segment counter loaded with a wrong length shifts every later bit. The fault shows by the next marker or the CRC, and at the latest as `done` and the fall of `busy` landing off the expected cycle count.
- A wrong CRC update, or a shifter misloaded at acceptance, stays hidden until the CRC slots. There the eight bits differ from the value the bench computes from the frame fields.
- Frame fields captured at the wrong time show up as a mismatch in the frame in flight after the inputs change mid-frame.

// File: rtl/fsx_pkg.sv
// Package: shared state encoding and fixed marker patterns for the
// framed serial transmitter. Assumes markers are 4 bits wide, sent MSB first.
package fsx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_BODY,
        ST_CRC,
        ST_TAG,
        ST_EOF,
        ST_POST
    } fsx_state_e;

    localparam int          MARK_W  = 4;
    localparam logic [3:0]  SOF_PAT = 4'b1001;
    localparam logic [3:0]  EOF_PAT = 4'b0110;

endpackage

// File: rtl/fsx_crc_ser.sv
// Bit-serial CRC, MSB-first, no reflection and no final XOR.
// Assumes clr and en are never both needed in one cycle; clr wins.
module fsx_crc_ser #(
    parameter int               CRC_W    = 8,
    parameter logic [CRC_W-1:0] CRC_POLY = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    logic fb;
    assign fb = crc[CRC_W-1] ^ din;

    // Purpose: clear the remainder or fold in one message bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= '0;
        else if (clr)
            crc <= '0;
        else if (en)
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

endmodule

// File: rtl/fsx_body_sr.sv
// Body shifter: loads type, user byte and all payload words left-justified,
// then shifts one bit per serial period. Word 0 is placed right after the
// header. Assumes the sequencer stops shifting after the selected word count.
module fsx_body_sr #(
    parameter int TYPE_W    = 4,
    parameter int USER_W    = 8,
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        shift,
    input  logic [TYPE_W-1:0]           frm_type,
    input  logic [USER_W-1:0]           user_data,
    input  logic [WORD_W*MAX_WORDS-1:0] payload,
    output logic                        bit_out
);

    localparam int LEN = TYPE_W + USER_W + WORD_W * MAX_WORDS;

    logic [LEN-1:0] img;
    logic [LEN-1:0] sr;

    assign img[LEN-1 -: TYPE_W]          = frm_type;
    assign img[LEN-TYPE_W-1 -: USER_W]   = user_data;

    // Reverse word order so word 0 leaves first after the header.
    for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
        assign img[WORD_W*(MAX_WORDS-i)-1 -: WORD_W] = payload[i*WORD_W +: WORD_W];
    end

    // Purpose: capture the frame image or advance it by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (load)
            sr <= img;
        else if (shift)
            sr <= {sr[LEN-2:0], 1'b0};
    end

    assign bit_out = sr[LEN-1];

endmodule

// File: rtl/fsx_seq.sv
// Frame sequencer: walks preamble, markers, body, CRC, tag and postamble,
// one bit per two core cycles (high half then low half), and generates the
// serial clock, the data mux, and the accept and done pulses.
// Assumes the body source and CRC unit advance on body_shift and crc_en.
module fsx_seq #(
    parameter int HDR_W      = 12,
    parameter int WORD_W     = 16,
    parameter int CNT_W      = 4,
    parameter int TAG_W      = 8,
    parameter int CRC_W      = 8,
    parameter int PRE_EDGES  = 4,
    parameter int POST_EDGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] n_words_m1,
    input  logic [TAG_W-1:0] tag,
    input  logic             body_bit,
    input  logic [CRC_W-1:0] crc,
    output logic             cap,
    output logic             body_shift,
    output logic             crc_en,
    output logic             ser_clk,
    output logic             ser_dat,
    output logic             busy,
    output logic             accept,
    output logic             done
);
    import fsx_pkg::*;

    localparam int MAX_BODY = HDR_W + WORD_W * (2 ** CNT_W);
    localparam int SLOT_W   = $clog2(MAX_BODY + PRE_EDGES + POST_EDGES + 64);
    localparam int CRC_IW   = $clog2(CRC_W);
    localparam int TAG_IW   = $clog2(TAG_W);

    fsx_state_e        state;
    logic              ph;
    logic [SLOT_W-1:0] cnt;
    logic [SLOT_W-1:0] body_last;
    logic [TAG_W-1:0]  tag_q;
    logic [CNT_W-1:0]  nw_q;
    logic              acc_q;
    logic              done_q;

    assign busy  = (state != ST_IDLE);
    assign cap   = (state == ST_IDLE) && req;
    assign body_last = SLOT_W'(HDR_W)
                     + SLOT_W'(WORD_W) * (SLOT_W'(nw_q) + SLOT_W'(1))
                     - SLOT_W'(1);

    // Purpose: advance phase, slot counter and segment state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph     <= 1'b0;
            cnt    <= '0;
            tag_q  <= '0;
            nw_q   <= '0;
            acc_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            acc_q  <= cap;
            done_q <= 1'b0;
            if (cap) begin
                state <= ST_PRE;
                ph    <= 1'b0;
                cnt   <= SLOT_W'(PRE_EDGES - 1);
                tag_q <= tag;
                nw_q  <= n_words_m1;
            end else if (busy) begin
                ph <= ~ph;
                if (ph) begin
                    if (cnt != '0) begin
                        cnt <= cnt - SLOT_W'(1);
                    end else begin
                        case (state)
                            ST_PRE:  begin state <= ST_SOF;  cnt <= SLOT_W'(MARK_W - 1);     end
                            ST_SOF:  begin state <= ST_BODY; cnt <= body_last;               end
                            ST_BODY: begin state <= ST_CRC;  cnt <= SLOT_W'(CRC_W - 1);      end
                            ST_CRC:  begin state <= ST_TAG;  cnt <= SLOT_W'(TAG_W - 1);      end
                            ST_TAG:  begin state <= ST_EOF;  cnt <= SLOT_W'(MARK_W - 1);     end
                            ST_EOF:  begin state <= ST_POST; cnt <= SLOT_W'(POST_EDGES - 1); end
                            ST_POST: begin state <= ST_IDLE; done_q <= 1'b1;                end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    // Purpose: body bits shift and feed the CRC at the end of each body period.
    assign body_shift = (state == ST_BODY) && ph;
    assign crc_en     = body_shift;

    // Purpose: choose the data bit for the current segment and slot.
    always_comb begin
        case (state)
            ST_SOF:  ser_dat = SOF_PAT[cnt[1:0]];
            ST_BODY: ser_dat = body_bit;
            ST_CRC:  ser_dat = crc[cnt[CRC_IW-1:0]];
            ST_TAG:  ser_dat = tag_q[cnt[TAG_IW-1:0]];
            ST_EOF:  ser_dat = EOF_PAT[cnt[1:0]];
            default: ser_dat = 1'b0;
        endcase
    end

    assign ser_clk = busy && !ph;
    assign accept  = acc_q;
    assign done    = done_q;

endmodule

// File: rtl/fsx_frame_tx.sv
// Top: framed serial transmitter. Captures a frame on an accepted request
// and serialises it with a half-rate forwarded clock. Assumes the producer
// holds req until accept and keeps the inputs valid in the requesting cycle.
module fsx_frame_tx #(
    parameter int         MAX_WORDS  = 16,
    parameter int         WORD_W     = 16,
    parameter int         TYPE_W     = 4,
    parameter int         USER_W     = 8,
    parameter int         TAG_W      = 8,
    parameter int         CRC_W      = 8,
    parameter logic [7:0] CRC_POLY   = 8'h07,
    parameter int         PRE_EDGES  = 4,
    parameter int         POST_EDGES = 4,
    localparam int        CNT_W      = $clog2(MAX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [TYPE_W-1:0]           frm_type,
    input  logic [USER_W-1:0]           user_data,
    input  logic [TAG_W-1:0]            tag,
    input  logic [CNT_W-1:0]            n_words_m1,
    input  logic [WORD_W*MAX_WORDS-1:0] payload,
    output logic                        ser_clk,
    output logic                        ser_dat,
    output logic                        busy,
    output logic                        accept,
    output logic                        done
);

    logic             cap;
    logic             body_shift;
    logic             crc_en;
    logic             body_bit;
    logic [CRC_W-1:0] crc;

    fsx_body_sr #(
        .TYPE_W(TYPE_W), .USER_W(USER_W), .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)
    ) u_body (
        .clk(clk), .rst_n(rst_n), .load(cap), .shift(body_shift),
        .frm_type(frm_type), .user_data(user_data), .payload(payload),
        .bit_out(body_bit)
    );

    fsx_crc_ser #(
        .CRC_W(CRC_W), .CRC_POLY(CRC_W'(CRC_POLY))
    ) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(cap), .en(crc_en), .din(body_bit),
        .crc(crc)
    );

    fsx_seq #(
        .HDR_W(TYPE_W + USER_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
        .TAG_W(TAG_W), .CRC_W(CRC_W),
        .PRE_EDGES(PRE_EDGES), .POST_EDGES(POST_EDGES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .n_words_m1(n_words_m1),
        .tag(tag), .body_bit(body_bit), .crc(crc),
        .cap(cap), .body_shift(body_shift), .crc_en(crc_en),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy),
        .accept(accept), .done(done)
    );

endmodule

// File: rtl/fsx_frame_tx_chk.sv
// Checker: port-level timing rules of the framed transmitter, bound to the top.
// Assumes reset is asserted for at least one clock at start-up.
module fsx_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_dat,
    input logic busy,
    input logic accept,
    input logic done
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_dat)); // R2

    AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (ser_clk != $past(ser_clk))); // R2

    AST_FIRST_HALF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ser_clk); // R2

    AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ser_clk) |-> $stable(ser_dat)); // R3

    AST_ACCEPT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> accept); // R4

    AST_ACCEPT_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $rose(busy)); // R4

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9

    AST_DONE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy)); // R9

endmodule

bind fsx_frame_tx fsx_frame_tx_chk u_chk (.*);

// File: tb/tb_fsx_frame_tx.sv
module tb_fsx_frame_tx;

    localparam int MAXW = 16;
    localparam int MAXT = 44 + 16 * MAXW;

    typedef struct {
        logic [3:0]   ty;
        logic [7:0]   ud;
        logic [7:0]   tg;
        logic [3:0]   nm1;
        logic [255:0] pl;
    } frm_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic [3:0]   frm_type = '0;
    logic [7:0]   user_data = '0;
    logic [7:0]   tag = '0;
    logic [3:0]   n_words_m1 = '0;
    logic [255:0] payload = '0;
    logic         ser_clk, ser_dat, busy, accept, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit exp_bits [MAXT];
    int exp_len;

    always #10 clk = ~clk;

    fsx_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .req(req), .frm_type(frm_type),
        .user_data(user_data), .tag(tag), .n_words_m1(n_words_m1),
        .payload(payload), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .busy(busy), .accept(accept), .done(done)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_step(input logic [7:0] c, input bit b);
        logic fb;
        fb = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    endfunction

    // Expected line bits per serial period, from the frame layout rules.
    task automatic build(input frm_t f);
        int k;
        logic [7:0] c;
        bit b;
        k = 0;
        c = '0;
        for (int i = 0; i < 4; i++) begin exp_bits[k] = 1'b0; k++; end
        for (int i = 3; i >= 0; i--) begin exp_bits[k] = (4'b1001 >> i) & 1; k++; end
        for (int i = 3; i >= 0; i--) begin
            b = f.ty[i]; exp_bits[k] = b; k++; c = crc_step(c, b);
        end
        for (int i = 7; i >= 0; i--) begin
            b = f.ud[i]; exp_bits[k] = b; k++; c = crc_step(c, b);
        end
        for (int w = 0; w <= int'(f.nm1); w++) begin
            for (int i = 15; i >= 0; i--) begin
                b = f.pl[w*16 + i]; exp_bits[k] = b; k++; c = crc_step(c, b);
            end
        end
        for (int i = 7; i >= 0; i--) begin exp_bits[k] = c[i]; k++; end
        for (int i = 7; i >= 0; i--) begin exp_bits[k] = f.tg[i]; k++; end
        for (int i = 3; i >= 0; i--) begin exp_bits[k] = (4'b0110 >> i) & 1; k++; end
        for (int i = 0; i < 4; i++) begin exp_bits[k] = 1'b0; k++; end
        exp_len = k;
    endtask

    task automatic apply(input frm_t f);
        frm_type   = f.ty;
        user_data  = f.ud;
        tag        = f.tg;
        n_words_m1 = f.nm1;
        payload    = f.pl;
    endtask

    task automatic rand_frame(output frm_t f);
        f.ty  = 4'($urandom);
        f.ud  = 8'($urandom);
        f.tg  = 8'($urandom);
        f.nm1 = 4'($urandom_range(0, 15));
        for (int w = 0; w < MAXW; w++) f.pl[w*16 +: 16] = 16'($urandom);
    endtask

    // Raise req at a negedge; accept is expected at the following negedge (R4).
    task automatic start_frame(input frm_t f);
        @(negedge clk);
        apply(f);
        req = 1'b1;
        @(negedge clk);
        chk("R4", "accept one cycle after request", int'(accept), 1);
        for (int i = 0; i < 8 && !accept; i++) @(negedge clk);
    endtask

    // Called at the sample of cycle 0 (first preamble cycle).
    task automatic track(input frm_t f, input bit swap, input frm_t nxt);
        int nclk, nbusy, nacc, ndone, npre, nhead, ntail, npost;
        int s, hend;
        build(f);
        hend = 8 + 12 + 16 * (int'(f.nm1) + 1);
        nclk = 0; nbusy = 0; nacc = 0; ndone = 0;
        npre = 0; nhead = 0; ntail = 0; npost = 0;
        for (int c = 0; c < 2 * exp_len; c++) begin
            if (c > 0) @(negedge clk);
            if (swap && c == 6) apply(nxt);
            s = c / 2;
            if (ser_clk !== ((c % 2) == 0)) nclk++;
            if (busy !== 1'b1) nbusy++;
            if (accept !== (c == 0)) nacc++;
            if (done !== 1'b0) ndone++;
            if (ser_dat !== exp_bits[s]) begin
                if (s < 4) npre++;
                else if (s < hend) nhead++;
                else if (s < hend + 20) ntail++;
                else npost++;
            end
        end
        chk("R2", "serial clock phase mismatches", nclk, 0);
        chk("R9", "busy low inside frame", nbusy, 0);
        chk("R4", "accept outside first cycle", nacc, 0);
        chk("R9", "done inside frame", ndone, 0);
        chk("R5", "preamble bit mismatches", npre, 0);
        chk("R6", "marker/header/word bit mismatches", nhead, 0);
        chk("R8", "crc/tag/end-marker bit mismatches", ntail, 0);
        chk("R9", "postamble bit mismatches", npost, 0);
        @(negedge clk);
        chk("R9", "done after postamble", int'(done), 1);
        chk("R9", "busy after postamble", int'(busy), 0);
        chk("R2", "idle lines after frame", int'({ser_clk, ser_dat}), 0);
        @(negedge clk);
        chk("R9", "done single pulse", int'(done), 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        frm_t f, g;
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        chk("R1", "outputs in reset", int'({ser_clk, ser_dat, busy, accept, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", int'({ser_clk, ser_dat, busy, accept, done}), 0);

        // Directed: one zero word, CRC of zeros is zero (R7, R8).
        f.ty = '0; f.ud = '0; f.tg = '0; f.nm1 = 4'd0; f.pl = '0;
        start_frame(f); req = 1'b0; track(f, 1'b0, f);

        // Directed: maximum word count with all-ones content (R7).
        f.ty = '1; f.ud = '1; f.tg = '1; f.nm1 = 4'd15; f.pl = '1;
        start_frame(f); req = 1'b0; track(f, 1'b0, f);

        // Directed: mixed fields, three words (R6, R8).
        f.ty = 4'hA; f.ud = 8'h5C; f.tg = 8'hC3; f.nm1 = 4'd2;
        f.pl = '0; f.pl[47:0] = 48'h8001_7E3C_1234;
        start_frame(f); req = 1'b0; track(f, 1'b0, f);

        // Random frames.
        for (int n = 0; n < 10; n++) begin
            rand_frame(f);
            start_frame(f); req = 1'b0; track(f, 1'b0, f);
        end

        // R10: request held through the frame, inputs changed mid-frame.
        rand_frame(f);
        rand_frame(g);
        start_frame(f);
        track(f, 1'b1, g);
        chk("R10", "held request accepted after done", int'(accept), 1);
        req = 1'b0;
        track(g, 1'b0, g);

        // R1: reset in the middle of a frame.
        rand_frame(f);
        start_frame(f); req = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "outputs after mid-frame reset", int'({ser_clk, ser_dat, busy, accept, done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "quiet after reset release", int'({ser_clk, ser_dat, busy, accept, done}), 0);

        // Fresh frame after the reset still correct.
        rand_frame(f);
        start_frame(f); req = 1'b0; track(f, 1'b0, f);

        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule